// File: doc/BRIEF.md
# Register File Read-Port Arbiter

This block lets several function-unit read requesters share a single register-file read port. Each requester offers a read request, a qualifier saying its function unit is active, a read flag saying the operand is really needed, and the register number it wants. A fixed-priority picker chooses at most one eligible requester per cycle. The chosen register number is placed on the port address, and read enable is raised in the same cycle.

The grant is captured in a per-requester register that becomes the requester's go-read pulse one cycle later. This matches a register file whose data appears one cycle after the address. During that cycle the port data is steered to the granted requester's source lane, and every other lane reads zero. The registered grant also takes the requester out of the next pick, so a requester that keeps asking is served every other cycle, and a lower-priority requester can use the cycle in between.

Top module: `rf_read_arbiter`

## Requirements
- R1: A requester is eligible only when its request, its active qualifier and its read flag are all high and its own go-read output is low; a requester that fails any of these conditions is never granted.
- R2: Among eligible requesters the lowest index wins, and at most one requester is granted per cycle.
- R3: In a grant cycle `port_addr` equals the winner's register number, taken from bits [i*REG_W +: REG_W] of `reg_num`. With no grant, `port_addr` is zero.
- R4: `port_ren` is high in exactly the cycles in which some requester is eligible. It is combinational, in the same cycle as the address.
- R5: Bit i of `go_rd` is high in the cycle after requester i was granted and low otherwise, so a grant gives a pulse of one cycle.
- R6: Lane i of `src_data`, bits [i*DATA_W +: DATA_W], equals `port_rdata` while bit i of `go_rd` is high and is zero otherwise.
- R7: While `rst` (active high, synchronous) is applied, all go-read registers clear. The first cycle after the reset edge shows `go_rd` at zero, whatever the requests are.
- R8: When several requesters keep requesting, a requester that has just been granted is masked for one cycle. The next eligible requester in priority order wins that cycle, and the grants alternate.
- R9: With a register file that returns data one cycle after enable, each granted requester receives on its lane the data stored at the register number it requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | N_REQ | Per-requester read request |
| fu_active | input | N_REQ | Per-requester function-unit active qualifier |
| rd_flag | input | N_REQ | Per-requester operand-needed flag |
| reg_num | input | N_REQ*REG_W | Packed register numbers, requester i at [i*REG_W +: REG_W] |
| port_addr | output | REG_W | Read-port address |
| port_ren | output | 1 | Read-port enable |
| port_rdata | input | DATA_W | Read-port data, valid one cycle after enable |
| go_rd | output | N_REQ | Registered per-requester go-read pulse |
| src_data | output | N_REQ*DATA_W | Per-requester source lanes, lane i at [i*DATA_W +: DATA_W] |

## Verification
The bench targets requesters that have a request but lack their qualifier or flag. A design that ignored either bit would grant them and drive their register number onto the address. Priority is probed with several requesters contending at different positions, where an inverted or missing priority chain picks the wrong winner or two at once. The bench also idles with no eligible requester, where a stale address or a stuck enable would show, and runs a reset with all requests pending, where go pulses must stay low. A continuous two-requester run checks the alternation and the data routing: with a missing mask the same requester would win every cycle, and with an unregistered go pulse or a wrong lane select the data would reach the wrong requester or arrive a cycle early.

// File: rtl/rdarb_pkg.sv
package rdarb_pkg;

    // Supported requester counts for one shared read port
    localparam int unsigned ARB_MIN_REQ = 1;
    localparam int unsigned ARB_MAX_REQ = 8;

    // True when a requester count is within the supported range
    function automatic bit req_count_ok(input int unsigned n);
        return (n >= ARB_MIN_REQ) && (n <= ARB_MAX_REQ);
    endfunction

    // Outcome of one arbitration cycle, as seen by the datapath
    typedef enum logic [0:0] {
        PORT_IDLE = 1'b0,
        PORT_BUSY = 1'b1
    } port_state_e;

endpackage

// File: rtl/rdarb_picker.sv
module rdarb_picker #(
    parameter int unsigned N_REQ = 4
) (
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] onehot,
    output logic             any
);
    // blocked[i] is set when some lower index is requesting
    logic [N_REQ:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N_REQ; i++) begin : g_chain
        assign blocked[i+1] = blocked[i] | req[i];
        assign onehot[i]    = req[i] & ~blocked[i];
    end

    assign any = blocked[N_REQ];
endmodule

// File: rtl/rdarb_addr_or.sv
module rdarb_addr_or #(
    parameter int unsigned N_REQ = 4,
    parameter int unsigned REG_W = 5
) (
    input  logic [N_REQ-1:0]       grant,
    input  logic [N_REQ*REG_W-1:0] reg_num,
    output logic [REG_W-1:0]       addr,
    output logic                   ren
);
    logic [REG_W-1:0] gated [N_REQ];

    // each lane drives zero unless granted
    for (genvar i = 0; i < N_REQ; i++) begin : g_gate
        assign gated[i] = grant[i] ? reg_num[i*REG_W +: REG_W] : '0;
    end

    always_comb begin
        addr = '0;
        for (int i = 0; i < N_REQ; i++) begin
            addr = addr | gated[i];
        end
    end

    assign ren = |grant;
endmodule

// File: rtl/rdarb_go_reg.sv
module rdarb_go_reg #(
    parameter int unsigned N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] grant,
    output logic [N_REQ-1:0] go
);
    always_ff @(posedge clk) begin
        if (rst) begin
            go <= '0;
        end else begin
            go <= grant;
        end
    end
endmodule

// File: rtl/rdarb_fanout.sv
module rdarb_fanout #(
    parameter int unsigned N_REQ  = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic [N_REQ-1:0]        go,
    input  logic [DATA_W-1:0]       rdata,
    output logic [N_REQ*DATA_W-1:0] lanes
);
    for (genvar i = 0; i < N_REQ; i++) begin : g_lane
        assign lanes[i*DATA_W +: DATA_W] = go[i] ? rdata : '0;
    end
endmodule

// File: rtl/rf_read_arbiter.sv
module rf_read_arbiter
    import rdarb_pkg::*;
#(
    parameter int unsigned N_REQ  = 4,
    parameter int unsigned REG_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REQ-1:0]        rd_req,
    input  logic [N_REQ-1:0]        fu_active,
    input  logic [N_REQ-1:0]        rd_flag,
    input  logic [N_REQ*REG_W-1:0]  reg_num,
    output logic [REG_W-1:0]        port_addr,
    output logic                    port_ren,
    input  logic [DATA_W-1:0]       port_rdata,
    output logic [N_REQ-1:0]        go_rd,
    output logic [N_REQ*DATA_W-1:0] src_data
);
    if (!req_count_ok(N_REQ)) begin : g_bad_count
        $error("rf_read_arbiter: N_REQ out of supported range");
    end

    logic [N_REQ-1:0] eligible;
    logic [N_REQ-1:0] pick_bits;
    logic             pick_any;
    logic [N_REQ-1:0] grant;
    port_state_e      port_state;

    // a requester with a go pulse in flight sits out this pick
    assign eligible = rd_req & fu_active & rd_flag & ~go_rd;

    rdarb_picker #(.N_REQ(N_REQ)) u_picker (
        .req    (eligible),
        .onehot (pick_bits),
        .any    (pick_any)
    );

    assign grant = pick_bits & {N_REQ{pick_any}};

    rdarb_addr_or #(.N_REQ(N_REQ), .REG_W(REG_W)) u_addr (
        .grant   (grant),
        .reg_num (reg_num),
        .addr    (port_addr),
        .ren     (port_ren)
    );

    assign port_state = port_ren ? PORT_BUSY : PORT_IDLE;

    rdarb_go_reg #(.N_REQ(N_REQ)) u_go (
        .clk   (clk),
        .rst   (rst),
        .grant (grant),
        .go    (go_rd)
    );

    rdarb_fanout #(.N_REQ(N_REQ), .DATA_W(DATA_W)) u_fan (
        .go    (go_rd),
        .rdata (port_rdata),
        .lanes (src_data)
    );
endmodule

// File: rtl/rf_read_arbiter_chk.sv
module rf_read_arbiter_chk #(
    parameter int unsigned N_REQ  = 4,
    parameter int unsigned REG_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic [N_REQ-1:0]        rd_req,
    input logic [N_REQ-1:0]        fu_active,
    input logic [N_REQ-1:0]        rd_flag,
    input logic [REG_W-1:0]        port_addr,
    input logic                    port_ren,
    input logic [DATA_W-1:0]       port_rdata,
    input logic [N_REQ-1:0]        go_rd,
    input logic [N_REQ*DATA_W-1:0] src_data
);
    logic [N_REQ-1:0] chk_ready;
    assign chk_ready = rd_req & fu_active & rd_flag & ~go_rd;

    a_r4_ren_tracks_ready: assert property (@(posedge clk) disable iff (rst)
        port_ren == (|chk_ready));

    a_r3_idle_addr_zero: assert property (@(posedge clk) disable iff (rst)
        !port_ren |-> (port_addr == '0));

    a_r5_go_after_ren: assert property (@(posedge clk) disable iff (rst)
        port_ren |=> ($countones(go_rd) == 1));

    a_r5_no_go_without_ren: assert property (@(posedge clk) disable iff (rst)
        !port_ren |=> (go_rd == '0));

    a_r2_single_go: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go_rd));

    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (go_rd == '0));

    for (genvar i = 0; i < N_REQ; i++) begin : g_lane
        a_r8_masked_after_go: assert property (@(posedge clk) disable iff (rst)
            go_rd[i] |=> !go_rd[i]);

        a_r6_lane_data: assert property (@(posedge clk) disable iff (rst)
            go_rd[i] |-> (src_data[i*DATA_W +: DATA_W] == port_rdata));

        a_r6_lane_zero: assert property (@(posedge clk) disable iff (rst)
            !go_rd[i] |-> (src_data[i*DATA_W +: DATA_W] == '0));
    end
endmodule

bind rf_read_arbiter rf_read_arbiter_chk #(
    .N_REQ  (N_REQ),
    .REG_W  (REG_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (rd_req),
    .fu_active  (fu_active),
    .rd_flag    (rd_flag),
    .port_addr  (port_addr),
    .port_ren   (port_ren),
    .port_rdata (port_rdata),
    .go_rd      (go_rd),
    .src_data   (src_data)
);

// File: tb/rf_read_arbiter_test.sv
module rf_read_arbiter_test;
    localparam int unsigned N  = 4;
    localparam int unsigned RW = 5;
    localparam int unsigned DW = 32;
    localparam logic [2:0]  NONE = 3'd7;

    // {req[3:0], active[3:0], flag[3:0], expected winner (7 = none)}
    localparam logic [14:0] VEC [9] = '{
        {4'b0001, 4'b1111, 4'b1111, 3'd0},
        {4'b1000, 4'b1111, 4'b1111, 3'd3},
        {4'b1111, 4'b1111, 4'b1111, 3'd0},
        {4'b1110, 4'b1111, 4'b1111, 3'd1},
        {4'b1111, 4'b1110, 4'b1111, 3'd1},
        {4'b1111, 4'b1111, 4'b1100, 3'd2},
        {4'b0101, 4'b1010, 4'b1111, NONE},
        {4'b0000, 4'b1111, 4'b1111, NONE},
        {4'b1100, 4'b1111, 4'b1011, 3'd3}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N-1:0]      rd_req = '0;
    logic [N-1:0]      fu_active = '0;
    logic [N-1:0]      rd_flag = '0;
    logic [N*RW-1:0]   reg_num;
    logic [RW-1:0]     port_addr;
    logic              port_ren;
    logic [DW-1:0]     port_rdata = '0;
    logic [N-1:0]      go_rd;
    logic [N*DW-1:0]   src_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rf_read_arbiter #(.N_REQ(N), .REG_W(RW), .DATA_W(DW)) uut (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .fu_active  (fu_active),
        .rd_flag    (rd_flag),
        .reg_num    (reg_num),
        .port_addr  (port_addr),
        .port_ren   (port_ren),
        .port_rdata (port_rdata),
        .go_rd      (go_rd),
        .src_data   (src_data)
    );

    function automatic logic [RW-1:0] reg_of(input int i);
        return RW'(3 + 7 * i);
    endfunction

    function automatic logic [DW-1:0] mem_val(input logic [RW-1:0] a);
        return 32'hC0DE_0000 | (32'(a) * 32'h111);
    endfunction

    for (genvar g = 0; g < N; g++) begin : g_regs
        assign reg_num[g*RW +: RW] = reg_of(g);
    end

    // register file model: one-cycle read latency
    always @(posedge clk) begin
        if (port_ren) port_rdata <= mem_val(port_addr);
    end

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic lane_checks(input logic [2:0] win, input string tag);
        for (int i = 0; i < N; i++) begin
            logic [DW-1:0] exp_d;
            logic [DW-1:0] got_d;
            got_d = src_data[i*DW +: DW];
            exp_d = (win != NONE && i == int'(win)) ? mem_val(reg_of(i)) : '0;
            check(got_d == exp_d, tag, got_d, exp_d);
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R7: reset with all requests pending keeps go pulses low
        rd_req = '1; fu_active = '1; rd_flag = '1;
        @(posedge clk); #1;
        check(go_rd == '0, "R7 go during reset", go_rd, 0);
        @(posedge clk); #1;
        check(go_rd == '0, "R7 go held in reset", go_rd, 0);
        rd_req = '0;
        rst = 1'b0;
        @(posedge clk); #1;
        check(go_rd == '0, "R7 go after reset", go_rd, 0);
        @(posedge clk); #1;

        // table walk: R1 R2 R3 R4 R5 R6 R9
        for (int v = 0; v < 9; v++) begin
            logic [2:0]    win;
            logic [RW-1:0] exp_a;
            logic [N-1:0]  exp_go;
            {rd_req, fu_active, rd_flag, win} = VEC[v];
            exp_a  = (win == NONE) ? '0 : reg_of(int'(win));
            exp_go = (win == NONE) ? '0 : N'(1) << win;
            #1;
            check(port_ren == (win != NONE), "R4 ren", port_ren, win != NONE);
            check(port_addr == exp_a, "R1 R2 R3 address of winner", port_addr, exp_a);
            @(posedge clk); #1;
            rd_req = '0;
            check(go_rd == exp_go, "R5 go pulse", go_rd, exp_go);
            lane_checks(win, "R6 R9 lane data");
            @(posedge clk); #1;
            check(go_rd == '0, "R5 go one cycle", go_rd, 0);
        end

        // R8: requesters 0 and 1 hold their requests, grants alternate
        rd_req = 4'b0011; fu_active = '1; rd_flag = '1;
        for (int c = 0; c < 6; c++) begin
            logic [2:0] w;
            w = (c % 2 == 0) ? 3'd0 : 3'd1;
            #1;
            check(port_addr == reg_of(int'(w)), "R8 alternating winner",
                  port_addr, reg_of(int'(w)));
            @(posedge clk); #1;
            check(go_rd == (N'(1) << w), "R8 go follows", go_rd, N'(1) << w);
            lane_checks(w, "R8 R9 alternating data");
        end
        rd_req = '0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check(go_rd == '0 && !port_ren, "R4 R5 idle after run", go_rd, 0);

        // R7: reset mid-grant clears the pending go
        rd_req = 4'b0100;
        #1;
        rst = 1'b1;
        @(posedge clk); #1;
        check(go_rd == '0, "R7 reset over grant", go_rd, 0);
        rst = 1'b0;
        rd_req = '0;
        @(posedge clk); #1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule